// File: doc/BRIEF.md
# Block Cipher Word-Serial Front End

This block is the control front end between a host and a 128-bit block cipher engine. The host first programs a configuration word while the block is disabled. That word carries the direction, the chaining style and the key length. The host also loads a key and an initial chaining value, then raises the enable bit. After that it streams in four 32-bit words to form one block. The block sends that block, with any chaining applied, to the engine through a request/done pair. When the engine answers, the block raises a completion flag and offers the four result words for the host to read.

The block supports electronic-codebook operation and cipher-block chaining in both directions. In chained encryption, the plaintext is combined with the chaining register before it reaches the engine, and the engine output becomes the new chaining value. In chained decryption, the engine output is combined with the chaining register, and the incoming ciphertext becomes the new chaining value. Blocks can follow one another under the same key without reprogramming.

Both word interfaces follow valid/ready rules, but neither can stall the block:
- **Input side:** `din_ready` is high only while the block is enabled, idle and has no pending result. A `din_valid` beat without `din_ready` is dropped.
- **Output side:** `dout_valid` is high while the flag is set and unread words remain. A `dout_ready` beat without `dout_valid` returns zero.

Both kinds of misuse set a sticky error bit.

Top module: `blkc_front`

## Requirements
- R1: The direction, chaining and key-size fields are taken on a control write only when enable is clear before that write. Key and IV loads are likewise accepted only while enable is clear. While enabled, such writes change nothing.
- R2: Direction field value 2'b10 drives `cph_decrypt` high; every other value runs encryption. A key-size bit of 1 drives `cph_key256` high.
- R3: Four accepted input beats form one block, the first beat landing in bits 127:96 and the fourth in bits 31:0. `cph_req` rises in the cycle after the fourth beat and stays high until `cph_done`.
- R4: Result words leave on `dout_data` most significant word first. `dout_valid` is high only while the flag is set and fewer than four words have been taken. `dout_data` reads zero whenever `dout_valid` is low.
- R5: `stat_ccf` rises in the cycle after `cph_done` and stays high until a control write with `ctrl_ccf_clr` set. `din_ready` is low while the flag is set, while a request is open, or while disabled.
- R6: With chaining field 3'b001 absent (any other value), the engine input is the assembled block and the result is the engine output unchanged.
- R7: With chaining field 3'b001 and encryption, the engine input is the block XOR the chaining register, and the engine output replaces the chaining register.
- R8: With chaining field 3'b001 and decryption, the result is the engine output XOR the chaining register, and the assembled ciphertext replaces the chaining register.
- R9: Chaining carries from block to block with no reprogramming. Loading the IV again while disabled restarts the chain.
- R10: A control write with `ctrl_en` low drops `cph_req` at the next cycle and restarts both word counters. Key and chaining register are kept.
- R11: A dropped input beat or an empty read sets `stat_err`, which stays set until a control write with `ctrl_err_clr`. If a new fault occurs in the same cycle as the clear, the error bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_en | input | 1 | Enable value written |
| ctrl_mode | input | 2 | Direction field (2'b10 decrypt) |
| ctrl_chain | input | 3 | Chaining field (3'b001 chained) |
| ctrl_ksz | input | 1 | Key length (1 = 256 bits) |
| ctrl_ccf_clr | input | 1 | Clears completion flag on a control write |
| ctrl_err_clr | input | 1 | Clears error bit on a control write |
| key_wr | input | 1 | Key load strobe |
| key_data | input | 256 | Key value |
| iv_wr | input | 1 | IV load strobe |
| iv_data | input | 128 | IV value |
| din_valid | input | 1 | Input word valid |
| din_data | input | 32 | Input word |
| din_ready | output | 1 | Input word accepted |
| dout_valid | output | 1 | Result word available |
| dout_data | output | 32 | Result word |
| dout_ready | input | 1 | Host takes result word |
| stat_en | output | 1 | Current enable |
| stat_ccf | output | 1 | Completion flag |
| stat_err | output | 1 | Sticky misuse bit |
| stat_busy | output | 1 | Engine request open |
| cph_req | output | 1 | Engine request, held until done |
| cph_decrypt | output | 1 | Engine direction |
| cph_key256 | output | 1 | Engine key length |
| cph_key | output | 256 | Engine key |
| cph_block | output | 128 | Engine input block |
| cph_done | input | 1 | Engine result strobe |
| cph_result | input | 128 | Engine result |

## Verification
A wrong input word count shows up at once as `cph_req` rising one beat early or late. It also shows up one engine latency later as a rotated or mixed result block. A stale or wrong chaining register stays hidden in the first block of a chain and appears only in the second. That is why chained runs cover two blocks and are then decrypted back to their plaintext. A flag or read-counter fault shows within a cycle on `dout_valid`, `din_ready` or `dout_data`. A reference model compared on every clock catches each of these at the cycle where it first becomes visible.

// File: rtl/blkc_pkg.sv
package blkc_pkg;

  localparam logic [1:0] MODE_DECRYPT = 2'b10;
  localparam logic [2:0] CHAIN_CBC    = 3'b001;

  typedef struct packed {
    logic dec;
    logic cbc;
    logic key256;
  } blkc_cfg_t;

  function automatic blkc_cfg_t decode_cfg(input logic [1:0] mode,
                                           input logic [2:0] chain,
                                           input logic       ksz);
    blkc_cfg_t c;
    c.dec    = (mode == MODE_DECRYPT);
    c.cbc    = (chain == CHAIN_CBC);
    c.key256 = ksz;
    return c;
  endfunction

endpackage

// File: rtl/blkc_cfg_regs.sv
module blkc_cfg_regs
  import blkc_pkg::*;
#(
  parameter int KEY_W = 256,
  parameter int BLK_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             ctrl_en,
  input  logic [1:0]       ctrl_mode,
  input  logic [2:0]       ctrl_chain,
  input  logic             ctrl_ksz,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_data,
  input  logic             iv_wr,
  input  logic [BLK_W-1:0] iv_data,
  input  logic             chain_upd,
  input  logic [BLK_W-1:0] chain_nxt,
  output logic             en,
  output blkc_cfg_t        cfg,
  output logic [KEY_W-1:0] key,
  output logic [BLK_W-1:0] chain
);

  // Settings move only while the enable seen before the edge is low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= 1'b0;
      cfg   <= '0;
      key   <= '0;
      chain <= '0;
    end else begin
      if (ctrl_wr) begin
        en <= ctrl_en;
        if (!en) cfg <= decode_cfg(ctrl_mode, ctrl_chain, ctrl_ksz);
      end
      if (key_wr && !en) key <= key_data;
      if (iv_wr && !en)   chain <= iv_data;
      else if (chain_upd) chain <= chain_nxt;
    end
  end

endmodule

// File: rtl/blkc_word_pack.sv
module blkc_word_pack #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     push,
  input  logic [WORD_W-1:0]        word,
  output logic                     last,
  output logic [WORD_W*WORDS-1:0]  block
);

  localparam int BLK_W = WORD_W * WORDS;
  localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [CNT_W-1:0] cnt;

  assign last = push && (cnt == CNT_W'(WORDS - 1));

  // Shift toward the top so the first word ends as the most significant one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      block <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (push) begin
      block <= (block << WORD_W) | BLK_W'(word);
      cnt   <= last ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/blkc_word_unpack.sv
module blkc_word_unpack #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    load,
  input  logic [WORD_W*WORDS-1:0] res_in,
  input  logic                    flag,
  input  logic                    pop,
  output logic                    dout_valid,
  output logic [WORD_W-1:0]       dout_data
);

  localparam int BLK_W = WORD_W * WORDS;
  localparam int CNT_W = $clog2(WORDS + 1);

  logic [BLK_W-1:0]  res;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] words [WORDS];
  logic [WORD_W-1:0] sel;

  for (genvar g = 0; g < WORDS; g++) begin : g_slice
    assign words[g] = res[BLK_W-1-g*WORD_W -: WORD_W];
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < WORDS; i++)
      if (cnt == CNT_W'(i)) sel = words[i];
  end

  assign dout_valid = flag && (cnt != CNT_W'(WORDS));
  assign dout_data  = dout_valid ? sel : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res <= '0;
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (load) begin
      res <= res_in;
      cnt <= '0;
    end else if (pop) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/blkc_chain_xor.sv
module blkc_chain_xor #(
  parameter int BLK_W = 128
) (
  input  logic             cbc,
  input  logic             dec,
  input  logic [BLK_W-1:0] blk,
  input  logic [BLK_W-1:0] chain,
  input  logic [BLK_W-1:0] eng_out,
  output logic [BLK_W-1:0] eng_in,
  output logic [BLK_W-1:0] result,
  output logic [BLK_W-1:0] chain_nxt
);

  // Encrypt mixes before the engine, decrypt mixes after it.
  assign eng_in    = (cbc && !dec) ? (blk ^ chain) : blk;
  assign result    = (cbc && dec) ? (eng_out ^ chain) : eng_out;
  assign chain_nxt = dec ? blk : eng_out;

endmodule

// File: rtl/blkc_front.sv
module blkc_front
  import blkc_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int KEY_W  = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ctrl_wr,
  input  logic                    ctrl_en,
  input  logic [1:0]              ctrl_mode,
  input  logic [2:0]              ctrl_chain,
  input  logic                    ctrl_ksz,
  input  logic                    ctrl_ccf_clr,
  input  logic                    ctrl_err_clr,
  input  logic                    key_wr,
  input  logic [KEY_W-1:0]        key_data,
  input  logic                    iv_wr,
  input  logic [WORD_W*WORDS-1:0] iv_data,
  input  logic                    din_valid,
  input  logic [WORD_W-1:0]       din_data,
  output logic                    din_ready,
  output logic                    dout_valid,
  output logic [WORD_W-1:0]       dout_data,
  input  logic                    dout_ready,
  output logic                    stat_en,
  output logic                    stat_ccf,
  output logic                    stat_err,
  output logic                    stat_busy,
  output logic                    cph_req,
  output logic                    cph_decrypt,
  output logic                    cph_key256,
  output logic [KEY_W-1:0]        cph_key,
  output logic [WORD_W*WORDS-1:0] cph_block,
  input  logic                    cph_done,
  input  logic [WORD_W*WORDS-1:0] cph_result
);

  localparam int BLK_W = WORD_W * WORDS;

  logic             en, busy, ccf, err;
  blkc_cfg_t        cfg;
  logic [KEY_W-1:0] key;
  logic [BLK_W-1:0] chain, chain_nxt, blk, result;
  logic             abort, push, last, done_ok, pop, fault;

  assign abort     = ctrl_wr && !ctrl_en;
  assign din_ready = en && !busy && !ccf;
  assign push      = din_valid && din_ready;
  assign done_ok   = busy && cph_done && !abort;
  assign pop       = dout_ready && dout_valid;
  assign fault     = (din_valid && !din_ready) || (dout_ready && !dout_valid);

  blkc_cfg_regs #(.KEY_W(KEY_W), .BLK_W(BLK_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_en    (ctrl_en),
    .ctrl_mode  (ctrl_mode),
    .ctrl_chain (ctrl_chain),
    .ctrl_ksz   (ctrl_ksz),
    .key_wr     (key_wr),
    .key_data   (key_data),
    .iv_wr      (iv_wr),
    .iv_data    (iv_data),
    .chain_upd  (done_ok && cfg.cbc),
    .chain_nxt  (chain_nxt),
    .en         (en),
    .cfg        (cfg),
    .key        (key),
    .chain      (chain)
  );

  blkc_word_pack #(.WORD_W(WORD_W), .WORDS(WORDS)) u_pack (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (abort),
    .push  (push),
    .word  (din_data),
    .last  (last),
    .block (blk)
  );

  blkc_chain_xor #(.BLK_W(BLK_W)) u_xor (
    .cbc       (cfg.cbc),
    .dec       (cfg.dec),
    .blk       (blk),
    .chain     (chain),
    .eng_out   (cph_result),
    .eng_in    (cph_block),
    .result    (result),
    .chain_nxt (chain_nxt)
  );

  blkc_word_unpack #(.WORD_W(WORD_W), .WORDS(WORDS)) u_unpack (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (abort),
    .load       (done_ok),
    .res_in     (result),
    .flag       (ccf),
    .pop        (pop),
    .dout_valid (dout_valid),
    .dout_data  (dout_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ccf  <= 1'b0;
      err  <= 1'b0;
    end else begin
      if (abort)                    busy <= 1'b0;
      else if (last)                busy <= 1'b1;
      else if (busy && cph_done)    busy <= 1'b0;

      if (done_ok)                          ccf <= 1'b1;
      else if (ctrl_wr && ctrl_ccf_clr)     ccf <= 1'b0;

      if (fault)                            err <= 1'b1;
      else if (ctrl_wr && ctrl_err_clr)     err <= 1'b0;
    end
  end

  assign stat_en     = en;
  assign stat_ccf    = ccf;
  assign stat_err    = err;
  assign stat_busy   = busy;
  assign cph_req     = busy;
  assign cph_decrypt = cfg.dec;
  assign cph_key256  = cfg.key256;
  assign cph_key     = key;

endmodule

// File: rtl/blkc_front_chk.sv
module blkc_front_chk #(
  parameter int KEY_W = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_wr,
  input logic             ctrl_en,
  input logic             ctrl_ccf_clr,
  input logic             din_valid,
  input logic             din_ready,
  input logic             dout_valid,
  input logic             stat_en,
  input logic             stat_ccf,
  input logic             stat_err,
  input logic             cph_req,
  input logic             cph_done,
  input logic             cph_decrypt,
  input logic             cph_key256,
  input logic [KEY_W-1:0] cph_key
);

  // R1: settings and key hold while enabled
  assert_cfg_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stat_en |=> $stable(cph_decrypt) && $stable(cph_key256) && $stable(cph_key));

  // R3: request held until the engine answers
  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cph_req && !cph_done && !(ctrl_wr && !ctrl_en) |=> cph_req);

  // R4: result words only offered under the flag with no request open
  assert_out_under_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> stat_ccf && !cph_req);

  // R5: flag rises after done
  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cph_req && cph_done && !(ctrl_wr && !ctrl_en) |=> stat_ccf && !cph_req);

  // R5: flag is sticky until the clear bit
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_ccf && !(ctrl_wr && ctrl_ccf_clr) |=> stat_ccf);

  // R10: disabling drops the request
  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !ctrl_en |=> !cph_req && !stat_en && !din_ready);

  // R11: dropped input beat sets the error bit
  assert_drop_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    din_valid && !din_ready |=> stat_err);

endmodule

bind blkc_front blkc_front_chk #(.KEY_W(KEY_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctrl_wr      (ctrl_wr),
  .ctrl_en      (ctrl_en),
  .ctrl_ccf_clr (ctrl_ccf_clr),
  .din_valid    (din_valid),
  .din_ready    (din_ready),
  .dout_valid   (dout_valid),
  .stat_en      (stat_en),
  .stat_ccf     (stat_ccf),
  .stat_err     (stat_err),
  .cph_req      (cph_req),
  .cph_done     (cph_done),
  .cph_decrypt  (cph_decrypt),
  .cph_key256   (cph_key256),
  .cph_key      (cph_key)
);

// File: tb/tb_blkc_front.sv
`timescale 1ns/1ps
module tb_blkc_front;

  localparam int LAT = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ctrl_wr = 0, ctrl_en = 0, ctrl_ksz = 0, ctrl_ccf_clr = 0, ctrl_err_clr = 0;
  logic [1:0]   ctrl_mode = 0;
  logic [2:0]   ctrl_chain = 0;
  logic         key_wr = 0, iv_wr = 0;
  logic [255:0] key_data = '0;
  logic [127:0] iv_data = '0;
  logic         din_valid = 0, dout_ready = 0;
  logic [31:0]  din_data = '0;
  logic         din_ready, dout_valid, stat_en, stat_ccf, stat_err, stat_busy;
  logic [31:0]  dout_data;
  logic         cph_req, cph_decrypt, cph_key256;
  logic [255:0] cph_key;
  logic [127:0] cph_block;
  logic         cph_done;
  logic [127:0] cph_result;

  int checks = 0, errors = 0, cyc = 0, s_cnt = 0;

  always #10 clk = ~clk;

  blkc_front dut (.*);

  // Invertible stand-in for the cipher.
  function automatic logic [127:0] eng(input logic [127:0] x, input logic [255:0] k,
                                       input logic dec, input logic k256);
    logic [127:0] kk, y;
    kk = k256 ? (k[255:128] ^ k[127:0]) : k[127:0];
    if (!dec) return {x[114:0], x[127:115]} ^ kk;
    y = x ^ kk;
    return {y[12:0], y[127:13]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_cnt <= 0; cph_done <= 1'b0; cph_result <= '0;
    end else if (!cph_req || cph_done) begin
      s_cnt <= 0; cph_done <= 1'b0;
    end else if (s_cnt == LAT - 1) begin
      cph_done <= 1'b1;
      cph_result <= eng(cph_block, cph_key, cph_decrypt, cph_key256);
    end else s_cnt <= s_cnt + 1;
  end

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic         m_en, m_dec, m_cbc, m_k256, m_busy, m_ccf, m_err;
  logic [255:0] m_key;
  logic [127:0] m_chain, m_blk, m_res;
  int           m_rd;
  logic [31:0]  m_inq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_dec = 0; m_cbc = 0; m_k256 = 0; m_busy = 0; m_ccf = 0; m_err = 0;
      m_key = '0; m_chain = '0; m_blk = '0; m_res = '0; m_rd = 0; m_inq.delete();
    end else begin
      logic rdy, dv, ab, dn;
      logic [127:0] ein, eo;
      rdy = m_en && !m_busy && !m_ccf;
      dv  = m_ccf && (m_rd < 4);
      ab  = ctrl_wr && !ctrl_en;
      dn  = m_busy && cph_done && !ab;
      if ((din_valid && !rdy) || (dout_ready && !dv)) m_err = 1;
      else if (ctrl_wr && ctrl_err_clr) m_err = 0;
      if (dout_ready && dv) m_rd++;
      if (dn) begin
        ein = (m_cbc && !m_dec) ? m_blk ^ m_chain : m_blk;
        eo = eng(ein, m_key, m_dec, m_k256);
        m_res = (m_cbc && m_dec) ? eo ^ m_chain : eo;
        if (m_cbc) m_chain = m_dec ? m_blk : eo;
        m_rd = 0; m_ccf = 1; m_busy = 0;
      end else if (ctrl_wr && ctrl_ccf_clr) m_ccf = 0;
      if (din_valid && rdy) begin
        m_inq.push_back(din_data);
        if (m_inq.size() == 4) begin
          m_blk = {m_inq[0], m_inq[1], m_inq[2], m_inq[3]};
          m_inq.delete();
          m_busy = 1;
        end
      end
      if (!m_en && key_wr) m_key = key_data;
      if (!m_en && iv_wr) m_chain = iv_data;
      if (ab) begin m_inq.delete(); m_busy = 0; m_rd = 0; end
      if (ctrl_wr) begin
        if (!m_en) begin
          m_dec = (ctrl_mode == 2'b10); m_cbc = (ctrl_chain == 3'b001); m_k256 = ctrl_ksz;
        end
        m_en = ctrl_en;
      end
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      logic dv;
      dv = m_ccf && (m_rd < 4);
      chk("R5 din_ready", din_ready, m_en && !m_busy && !m_ccf);
      chk("R5 stat_ccf", stat_ccf, m_ccf);
      chk("R4 dout_valid", dout_valid, dv);
      chk("R4 dout_data", dout_data, dv ? m_res[127-32*m_rd -: 32] : 32'h0);
      chk("R11 stat_err", stat_err, m_err);
      chk("R3 cph_req", cph_req, m_busy);
      chk("R3 stat_busy", stat_busy, m_busy);
      chk("R10 stat_en", stat_en, m_en);
      chk("R2 cph_decrypt", cph_decrypt, m_dec);
      chk("R2 cph_key256", cph_key256, m_k256);
      if (m_busy)
        chk(m_cbc ? "R7 cph_block" : "R6 cph_block", cph_block,
            (m_cbc && !m_dec) ? m_blk ^ m_chain : m_blk);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus tasks (entered just after a negedge) ----------------
  task automatic ctrl(input logic en, input logic [1:0] md, input logic [2:0] ch,
                      input logic ks, input logic cc, input logic ec);
    ctrl_wr = 1; ctrl_en = en; ctrl_mode = md; ctrl_chain = ch; ctrl_ksz = ks;
    ctrl_ccf_clr = cc; ctrl_err_clr = ec;
    @(negedge clk);
    ctrl_wr = 0; ctrl_ccf_clr = 0; ctrl_err_clr = 0;
  endtask

  task automatic ld_key(input logic [255:0] k);
    key_wr = 1; key_data = k; @(negedge clk); key_wr = 0;
  endtask

  task automatic ld_iv(input logic [127:0] v);
    iv_wr = 1; iv_data = v; @(negedge clk); iv_wr = 0;
  endtask

  task automatic setup(input logic [1:0] md, input logic [2:0] ch, input logic ks);
    ctrl(0, md, ch, ks, 0, 0);
    ctrl(0, md, ch, ks, 0, 0);
    ctrl(1, md, ch, ks, 0, 0);
  endtask

  task automatic wr(input logic [31:0] w);
    din_valid = 1; din_data = w; @(negedge clk); din_valid = 0;
  endtask

  task automatic rd(output logic [31:0] w);
    w = dout_data; dout_ready = 1; @(negedge clk); dout_ready = 0;
  endtask

  task automatic wait_ccf();
    int t;
    t = 0;
    while (!stat_ccf && t < 100) begin @(negedge clk); t++; end
    chk("R5 flag raised", stat_ccf, 1'b1);
  endtask

  task automatic blk(input logic [127:0] p, output logic [127:0] c);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) wr(p[127-32*i -: 32]);
    chk("R3 request after fourth word", cph_req, 1'b1);
    wait_ccf();
    for (int i = 0; i < 4; i++) begin rd(w); c[127-32*i -: 32] = w; end
    ctrl(1, 2'b00, 3'b000, 0, 1, 0);
  endtask

  localparam logic [255:0] K1 = 256'h0f1e2d3c4b5a69788796a5b4c3d2e1f0_00112233445566778899aabbccddeeff;
  localparam logic [255:0] K2 = 256'h13579bdf02468ace_fedcba9876543210_a5a5a5a55a5a5a5a_0123456789abcdef;
  localparam logic [127:0] IV = 128'hcafef00d_deadbeef_01234567_89abcdef;
  localparam logic [127:0] P0 = 128'h11111111_22222222_33333333_44444444;
  localparam logic [127:0] P1 = 128'h80000001_7ffffffe_00000000_ffffffff;
  localparam logic [127:0] P2 = 128'h0badf00d_feedface_12345678_9abcdef0;
  localparam logic [127:0] P3 = 128'h00000000_00000000_00000000_00000001;
  localparam logic [127:0] P4 = 128'h55aa55aa_aa55aa55_0f0f0f0f_f0f0f0f0;
  localparam logic [127:0] P5 = 128'hffffffff_00000000_ffffffff_00000000;

  initial begin
    logic [127:0] c, c0, c1;
    logic [31:0]  w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    chk("R5 reset din_ready", din_ready, 1'b0);
    chk("R4 reset dout_valid", dout_valid, 1'b0);
    chk("R3 reset cph_req", cph_req, 1'b0);
    chk("R11 reset stat_err", stat_err, 1'b0);
    @(negedge clk);

    // plain codebook, 128-bit key
    ld_key(K1); ld_iv(IV);
    setup(2'b00, 3'b000, 0);
    blk(P0, c);
    chk("R6 ECB result", c, eng(P0, K1, 0, 0));

    // misuse during a computation
    for (int i = 0; i < 4; i++) wr(P1[127-32*i -: 32]);
    wr(32'hdeadbeef);
    rd(w);
    chk("R4 early read is zero", w, 32'h0);
    chk("R11 error after dropped beat", stat_err, 1'b1);
    wait_ccf();
    repeat (5) @(negedge clk);
    chk("R5 flag held", stat_ccf, 1'b1);
    chk("R5 no input while flagged", din_ready, 1'b0);
    for (int i = 0; i < 4; i++) begin rd(w); c[127-32*i -: 32] = w; end
    chk("R3 extra beat ignored", c, eng(P1, K1, 0, 0));
    rd(w);
    chk("R4 read past end is zero", w, 32'h0);
    ctrl(1, 2'b00, 3'b000, 0, 1, 1);
    chk("R11 error cleared", stat_err, 1'b0);
    chk("R5 flag cleared", stat_ccf, 1'b0);

    // settings and key while enabled are ignored
    ctrl(1, 2'b10, 3'b001, 1, 0, 0);
    ld_key(K2); ld_iv(P5);
    blk(P2, c);
    chk("R1 settings frozen while enabled", c, eng(P2, K1, 0, 0));

    // chained encryption over two blocks
    setup(2'b00, 3'b001, 0);
    ld_iv(IV);
    chk("R1 IV refused while enabled", stat_en, 1'b1);
    setup(2'b00, 3'b001, 0);
    ctrl(0, 2'b00, 3'b001, 0, 0, 0);
    ld_iv(IV);
    ctrl(1, 2'b00, 3'b001, 0, 0, 0);
    blk(P0, c0);
    chk("R7 CBC first block", c0, eng(P0 ^ IV, K1, 0, 0));
    blk(P1, c1);
    chk("R9 CBC second block", c1, eng(P1 ^ c0, K1, 0, 0));

    // chained decryption back to plaintext
    ctrl(0, 2'b10, 3'b001, 0, 0, 0);
    ld_iv(IV);
    ctrl(1, 2'b10, 3'b001, 0, 0, 0);
    blk(c0, c);
    chk("R8 CBC decrypt first block", c, P0);
    blk(c1, c);
    chk("R9 CBC decrypt second block", c, P1);

    // 256-bit key, odd field values fall back to encrypt / codebook
    ctrl(0, 2'b01, 3'b010, 1, 0, 0);
    ld_key(K2);
    ctrl(1, 2'b01, 3'b010, 1, 0, 0);
    blk(P3, c);
    chk("R2 long key and mode 01 encrypts", c, eng(P3, K2, 0, 1));

    // disable mid-block restarts word count, keeps key
    wr(32'h99999999); wr(32'h88888888);
    ctrl(0, 2'b01, 3'b010, 1, 0, 0);
    chk("R10 disabled", din_ready, 1'b0);
    ctrl(1, 2'b01, 3'b010, 1, 0, 0);
    blk(P4, c);
    chk("R10 partial block discarded", c, eng(P4, K2, 0, 1));

    // disable while a request is open
    for (int i = 0; i < 4; i++) wr(P5[127-32*i -: 32]);
    ctrl(0, 2'b01, 3'b010, 1, 0, 0);
    chk("R10 request dropped", cph_req, 1'b0);
    repeat (6) @(negedge clk);
    chk("R10 no flag after abort", stat_ccf, 1'b0);
    ctrl(1, 2'b01, 3'b010, 1, 0, 0);
    blk(P5, c);
    chk("R10 resumes after abort", c, eng(P5, K2, 0, 1));

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule